// File: doc/BRIEF.md
# Compare and Branch Resolution Unit

This unit resolves control flow for a small 16-bit instruction encoding with 32-bit data. Each cycle that `in_valid` is high it receives one instruction halfword, the two source register values already read for it, the 32-bit word that follows the halfword in the instruction stream, and the address of the instruction. One clock later it presents the address of the next instruction, a taken flag and an illegal-instruction flag.

A compare instruction loads a 5-bit condition-code register. Ten conditional branches test that register. One unconditional absolute jump ignores it. The condition code is held inside the unit, so a branch issued right after a compare sees that compare's result. The two 3-bit register selector fields are decoded combinationally, so a register file outside the unit can read the operands in the same cycle. Fetch, the register file, memory and subroutine calls stay outside the unit.

Top module: `cmp_branch_unit`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, the condition code reads 0 and `out_valid`, `taken` and `illegal` are all low.
- R2: `src_a_sel` always equals instruction bits 8:6 and `src_b_sel` always equals bits 5:3, in the same cycle. The opcode is bits 15:9.
- R3: A compare (opcode 0x0d) with equal operands leaves the condition code at exactly 5'b00100, meaning only the equal flag (bit 2) is set.
- R4: A compare with unequal operands clears bit 2. It sets bit 1 if A < B as signed, bit 0 if A > B as signed, bit 4 if A < B as unsigned, and bit 3 if A > B as unsigned.
- R5: A compare reports `next_pc` = instruction address + 2, with `taken` low.
- R6: The branch opcodes are 0x0e through 0x17, and each is taken on its own condition. In opcode order these are: bit2, not bit2, bit1, bit0, bit4, bit3, bit0 or bit2, bit1 or bit2, bit3 or bit2, bit4 or bit2. Each branch tests the condition code as it stands before the branch.
- R7: A taken branch reports `next_pc` = the following word with `taken` high. A branch that is not taken reports instruction address + 6 with `taken` low.
- R8: Opcode 0x19 always reports `next_pc` = the following word with `taken` high.
- R9: The condition code changes only on a valid compare. Branches, jumps, illegal opcodes and idle cycles leave it unchanged.
- R10: Any other opcode raises `illegal` for exactly one cycle, with `next_pc` = instruction address and `taken` low. This includes 0x18 and 0x1a–0x7f.
- R11: Results appear one cycle after the instruction is presented. A cycle with `in_valid` low gives `out_valid` and `illegal` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| insn | input | 16 | Instruction halfword |
| opa | input | 32 | Value of register selected by src_a_sel |
| opb | input | 32 | Value of register selected by src_b_sel |
| imm_word | input | 32 | Word following the halfword (absolute target) |
| pc_in | input | 32 | Address of the instruction |
| src_a_sel | output | 3 | First source register index |
| src_b_sel | output | 3 | Second source register index |
| out_valid | output | 1 | Registered result valid |
| next_pc | output | 32 | Address of the next instruction |
| taken | output | 1 | Control transfer to imm_word |
| illegal | output | 1 | Unrecognised opcode pulse |
| cc | output | 5 | Condition-code register |

## Verification
The assertions assume that `insn`, `opa`, `opb`, `imm_word` and `pc_in` are stable and fully driven whenever `in_valid` is high. They also assume that `opa`/`opb` already hold the values for the selectors decoded in that cycle. The bench follows these rules by changing every input only on the falling edge and presenting each instruction for one cycle with all of its operands. It drops `in_valid` between instructions so that idle cycles are exercised as well. For a set of operand pairs chosen at sign and magnitude boundaries, the bench compares once and then sweeps all 128 opcodes against the resulting condition code.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int OPC_W  = 7;
  localparam int CC_W   = 5;
  localparam int NCOND  = 10;
  localparam int COND_W = 4;

  localparam logic [OPC_W-1:0] OP_CMP  = 7'h0d;
  localparam logic [OPC_W-1:0] OP_BR_LO = 7'h0e;
  localparam logic [OPC_W-1:0] OP_BR_HI = 7'h17;
  localparam logic [OPC_W-1:0] OP_JMPA = 7'h19;

  // condition-code bit positions
  localparam int CC_GT  = 0;
  localparam int CC_LT  = 1;
  localparam int CC_EQ  = 2;
  localparam int CC_GTU = 3;
  localparam int CC_LTU = 4;

  typedef enum logic [1:0] {
    CL_ILL = 2'd0,
    CL_CMP = 2'd1,
    CL_BR  = 2'd2,
    CL_JMP = 2'd3
  } op_class_e;

  // flags each branch looks at, indexed by opcode - OP_BR_LO
  function automatic logic [CC_W-1:0] cond_mask(input int k);
    logic [CC_W-1:0] m;
    m = '0;
    case (k)
      0, 1: m[CC_EQ] = 1'b1;
      2: m[CC_LT] = 1'b1;
      3: m[CC_GT] = 1'b1;
      4: m[CC_LTU] = 1'b1;
      5: m[CC_GTU] = 1'b1;
      6: begin m[CC_GT] = 1'b1;  m[CC_EQ] = 1'b1; end
      7: begin m[CC_LT] = 1'b1;  m[CC_EQ] = 1'b1; end
      8: begin m[CC_GTU] = 1'b1; m[CC_EQ] = 1'b1; end
      9: begin m[CC_LTU] = 1'b1; m[CC_EQ] = 1'b1; end
      default: m = '0;
    endcase
    return m;
  endfunction

  // only the not-equal branch inverts its test
  function automatic logic cond_invert(input int k);
    return (k == 1);
  endfunction
endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
  import cbu_pkg::*;
#(
  parameter int INSN_W = 16,
  parameter int REG_W  = 3
) (
  input  logic [INSN_W-1:0] insn,
  output logic [REG_W-1:0]  sel_a,
  output logic [REG_W-1:0]  sel_b,
  output op_class_e         cls,
  output logic [COND_W-1:0] cond_sel
);
  localparam int OPC_LSB = INSN_W - OPC_W;
  localparam int A_LSB   = OPC_LSB - REG_W;
  localparam int B_LSB   = A_LSB - REG_W;

  logic [OPC_W-1:0] opc;
  logic [OPC_W-1:0] br_off;

  assign opc    = insn[INSN_W-1:OPC_LSB];
  assign sel_a  = insn[A_LSB +: REG_W];
  assign sel_b  = insn[B_LSB +: REG_W];
  assign br_off = opc - OP_BR_LO;
  assign cond_sel = br_off[COND_W-1:0];

  always_comb begin
    if (opc == OP_CMP)
      cls = CL_CMP;
    else if (opc >= OP_BR_LO && opc <= OP_BR_HI)
      cls = CL_BR;
    else if (opc == OP_JMPA)
      cls = CL_JMP;
    else
      cls = CL_ILL;
  end
endmodule

// File: rtl/cbu_ccgen.sv
module cbu_ccgen
  import cbu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [CC_W-1:0]   flags
);
  logic eq, lt_s, gt_s, lt_u, gt_u;

  assign eq   = (a == b);
  assign lt_u = (a < b);
  assign gt_u = (a > b);
  assign lt_s = ($signed(a) < $signed(b));
  assign gt_s = ($signed(a) > $signed(b));

  always_comb begin
    flags = '0;
    if (eq) begin
      flags[CC_EQ] = 1'b1;
    end else begin
      flags[CC_LT]  = lt_s;
      flags[CC_GT]  = gt_s;
      flags[CC_LTU] = lt_u;
      flags[CC_GTU] = gt_u;
    end
  end
endmodule

// File: rtl/cbu_cond.sv
module cbu_cond
  import cbu_pkg::*;
(
  input  logic [CC_W-1:0]   cc,
  input  logic [COND_W-1:0] sel,
  output logic              take
);
  logic [NCOND-1:0] hit;

  for (genvar k = 0; k < NCOND; k++) begin : g_cond
    localparam logic [CC_W-1:0] MASK = cond_mask(k);
    localparam logic            INV  = cond_invert(k);
    assign hit[k] = (|(cc & MASK)) ^ INV;
  end

  always_comb begin
    take = 1'b0;
    for (int k = 0; k < NCOND; k++)
      if (sel == COND_W'(k)) take = hit[k];
  end
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSN_W  = 16,
  parameter int REG_W   = 3,
  parameter int CMP_LEN = 2,
  parameter int BR_LEN  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] imm_word,
  input  logic [DATA_W-1:0] pc_in,
  output logic [REG_W-1:0]  src_a_sel,
  output logic [REG_W-1:0]  src_b_sel,
  output logic              out_valid,
  output logic [DATA_W-1:0] next_pc,
  output logic              taken,
  output logic              illegal,
  output logic [CC_W-1:0]   cc
);
  localparam logic [DATA_W-1:0] CMP_STEP = DATA_W'(CMP_LEN);
  localparam logic [DATA_W-1:0] BR_STEP  = DATA_W'(BR_LEN);

  op_class_e         cls;
  logic [COND_W-1:0] cond_sel;
  logic [CC_W-1:0]   new_flags;
  logic              br_take;
  logic [DATA_W-1:0] pc_d;
  logic              taken_d;

  cbu_decode #(.INSN_W(INSN_W), .REG_W(REG_W)) u_dec (
    .insn(insn), .sel_a(src_a_sel), .sel_b(src_b_sel),
    .cls(cls), .cond_sel(cond_sel)
  );

  cbu_ccgen #(.DATA_W(DATA_W)) u_ccg (
    .a(opa), .b(opb), .flags(new_flags)
  );

  cbu_cond u_cond (
    .cc(cc), .sel(cond_sel), .take(br_take)
  );

  always_comb begin
    pc_d    = pc_in;
    taken_d = 1'b0;
    case (cls)
      CL_CMP: pc_d = pc_in + CMP_STEP;
      CL_BR: begin
        taken_d = br_take;
        pc_d    = br_take ? imm_word : pc_in + BR_STEP;
      end
      CL_JMP: begin
        taken_d = 1'b1;
        pc_d    = imm_word;
      end
      default: begin
        pc_d    = pc_in;
        taken_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      illegal   <= 1'b0;
      next_pc   <= '0;
      cc        <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid && (cls == CL_ILL);
      taken     <= in_valid && taken_d;
      if (in_valid) next_pc <= pc_d;
      if (in_valid && cls == CL_CMP) cc <= new_flags;
    end
  end

  // R1: reset state
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cc == '0 && !out_valid && !taken && !illegal));

  // R3: equal operands give only the equal flag
  a_r3_eq_only: assert property (@(posedge clk) disable iff (rst)
    (in_valid && insn[INSN_W-1 -: OPC_W] == OP_CMP && opa == opb)
    |=> (cc == CC_W'(1 << CC_EQ)));

  // R4: orderings are mutually exclusive and never mix with equal
  a_r4_order_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cc[CC_LT], cc[CC_GT]}) && $onehot0({cc[CC_LTU], cc[CC_GTU]})
    && (cc[CC_EQ] -> $countones(cc) == 1));

  // R7: an untaken branch falls through by the branch length
  a_r7_fallthrough: assert property (@(posedge clk) disable iff (rst)
    (in_valid && insn[INSN_W-1 -: OPC_W] >= OP_BR_LO && insn[INSN_W-1 -: OPC_W] <= OP_BR_HI)
    |=> (taken ? next_pc == $past(imm_word) : next_pc == $past(pc_in) + BR_STEP));

  // R8: absolute jump always transfers
  a_r8_jump: assert property (@(posedge clk) disable iff (rst)
    (in_valid && insn[INSN_W-1 -: OPC_W] == OP_JMPA)
    |=> (taken && next_pc == $past(imm_word)));

  // R9: condition code only moves on a compare
  a_r9_cc_hold: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && insn[INSN_W-1 -: OPC_W] == OP_CMP) |=> $stable(cc));

  // R10: illegal opcode keeps the pc and does not transfer
  a_r10_illegal_pc: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!taken && next_pc == $past(pc_in)));

  // R11: idle cycle yields no result
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !illegal));
endmodule

// File: tb/cmp_branch_unit_bench.sv
module cmp_branch_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] insn = '0;
  logic [31:0] opa = '0, opb = '0, imm_word = '0, pc_in = '0;
  logic [2:0]  src_a_sel, src_b_sel;
  logic        out_valid, taken, illegal;
  logic [31:0] next_pc;
  logic [4:0]  cc;

  int total = 0;
  int bad = 0;
  logic [4:0] m_cc = '0;

  always #5 clk = ~clk;

  cmp_branch_unit u_cmp_branch_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .opa(opa), .opb(opb), .imm_word(imm_word), .pc_in(pc_in),
    .src_a_sel(src_a_sel), .src_b_sel(src_b_sel),
    .out_valid(out_valid), .next_pc(next_pc), .taken(taken),
    .illegal(illegal), .cc(cc)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_cc(input logic [31:0] a, input logic [31:0] b);
    logic [4:0] r;
    r = '0;
    if (a == b) r = 5'b00100;
    else begin
      r[1] = $signed(a) < $signed(b);
      r[0] = $signed(a) > $signed(b);
      r[4] = a < b;
      r[3] = a > b;
    end
    return r;
  endfunction

  function automatic logic ref_take(input int k, input logic [4:0] c);
    case (k)
      0: return c[2];
      1: return !c[2];
      2: return c[1];
      3: return c[0];
      4: return c[4];
      5: return c[3];
      6: return c[0] | c[2];
      7: return c[1] | c[2];
      8: return c[3] | c[2];
      9: return c[4] | c[2];
      default: return 1'b0;
    endcase
  endfunction

  task automatic run(input logic [6:0] opc, input logic [2:0] ra, input logic [2:0] rb,
                     input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] pc, input logic [31:0] tgt);
    logic [31:0] e_pc;
    logic        e_tk, e_il;
    logic [4:0]  e_cc;
    @(negedge clk);
    insn = {opc, ra, rb, 3'b101};
    opa = a; opb = b; pc_in = pc; imm_word = tgt; in_valid = 1'b1;
    #1;
    chk(src_a_sel == ra && src_b_sel == rb, "R2 selectors",
        {58'd0, src_a_sel, src_b_sel}, {58'd0, ra, rb});
    e_cc = m_cc; e_tk = 1'b0; e_il = 1'b0; e_pc = pc;
    if (opc == 7'h0d) begin
      e_cc = ref_cc(a, b); e_pc = pc + 2;
    end else if (opc >= 7'h0e && opc <= 7'h17) begin
      e_tk = ref_take(int'(opc) - 14, m_cc);
      e_pc = e_tk ? tgt : pc + 6;
    end else if (opc == 7'h19) begin
      e_tk = 1'b1; e_pc = tgt;
    end else begin
      e_il = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (opc == 7'h0d) begin
      chk(cc == e_cc, (a == b) ? "R3 equal cc" : "R4 ordered cc", {59'd0, cc}, {59'd0, e_cc});
      chk(next_pc == e_pc && !taken && !illegal, "R5 compare pc", {31'd0, taken, next_pc}, {32'd0, e_pc});
    end else if (opc >= 7'h0e && opc <= 7'h17) begin
      chk(taken == e_tk, "R6 branch cond", {63'd0, taken}, {63'd0, e_tk});
      chk(next_pc == e_pc && !illegal, "R7 branch pc", {32'd0, next_pc}, {32'd0, e_pc});
    end else if (opc == 7'h19) begin
      chk(taken && next_pc == e_pc && !illegal, "R8 jump", {31'd0, taken, next_pc}, {31'd0, 1'b1, e_pc});
    end else begin
      chk(illegal && !taken && next_pc == e_pc, "R10 illegal", {30'd0, illegal, taken, next_pc}, {30'd0, 2'b10, e_pc});
    end
    chk(out_valid, "R11 result valid", {63'd0, out_valid}, 64'd1);
    chk(cc == e_cc, "R9 cc value", {59'd0, cc}, {59'd0, e_cc});
    m_cc = e_cc;
    if (e_il) begin
      @(negedge clk);
      chk(!illegal && !out_valid, "R10 one-cycle pulse / R11 idle",
          {62'd0, illegal, out_valid}, 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] pa [8];
    logic [31:0] pb [8];
    pa[0] = 32'd5;        pb[0] = 32'd5;
    pa[1] = 32'd1;        pb[1] = 32'd2;
    pa[2] = 32'd2;        pb[2] = 32'd1;
    pa[3] = 32'hffffffff; pb[3] = 32'd1;
    pa[4] = 32'd1;        pb[4] = 32'hffffffff;
    pa[5] = 32'h80000000; pb[5] = 32'h7fffffff;
    pa[6] = 32'h7fffffff; pb[6] = 32'h80000000;
    pa[7] = 32'd0;        pb[7] = 32'd0;

    repeat (3) @(negedge clk);
    chk(cc == 0 && !out_valid && !taken && !illegal, "R1 reset in",
        {56'd0, cc, out_valid, taken, illegal}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(cc == 0 && !out_valid && !illegal, "R1 reset out",
        {57'd0, cc, out_valid, illegal}, 64'd0);

    for (int p = 0; p < 8; p++) begin
      run(7'h0d, 3'(p), 3'(7 - p), pa[p], pb[p], 32'h1000 + 32'(p * 64), 32'h0);
      for (int o = 0; o < 128; o++) begin
        if (o != 13)
          run(7'(o), 3'(o), 3'(~o), 32'hdead0000 + 32'(o), 32'h0000beef,
              32'h2000 + 32'(o * 8), 32'h40000000 + 32'(o * 4 + p));
      end
    end

    // idle cycle check
    @(negedge clk);
    chk(!out_valid && !illegal, "R11 idle", {62'd0, out_valid, illegal}, 64'd0);

    // reset mid-run returns cc to zero
    run(7'h0d, 3'd1, 3'd2, 32'd3, 32'd9, 32'h3000, 32'h0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_cc = '0;
    @(negedge clk);
    chk(cc == 0 && !out_valid, "R1 reset mid-run", {58'd0, cc, out_valid}, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule